// File: doc/BRIEF.md
# Interrupt Enable and Masking Unit

This unit decides whether a combined interrupt request is sent to the processor core. Interrupt requests arrive on one pending line per register module (six by default) and on one line that collects every system-module source. Two byte-wide registers that software can write control the gating. The control register holds a global enable, an in-service flag and a clock-gating-disable bit. The mask register holds one enable bit per module and one bit that covers all system sources.

When the core accepts an interrupt, it pulses an acknowledge. The in-service flag then sets and blocks any further request. A handler that wants nested interrupts writes the flag back to 0. Otherwise the flag clears when the core pulses the return strobe, which comes from a return-from-interrupt or pop-interrupt instruction. The unit does not generate vectors and does not rank modules by priority. It only qualifies the request and forwards it.

Top module: `irq_gate_unit`

## Requirements
- R1: After reset, both registers read 8'h00, `irqReq` is 0 and `clkGateDis` is 0.
- R2: When control bit 0 (global enable) is 0, `irqReq` is 0 whatever the pending lines and the mask hold.
- R3: `irqReq` = GE AND NOT INS AND the OR over modules of (`modPend[i]` AND mask bit i), where i runs from 0 to 5. The output is combinational in the current pending inputs.
- R4: Mask bit 7 gates `sysPend` into the same OR.
- R5: An `irqAck` pulse sets control bit 1 (in-service) at the next clock edge. While that bit is 1, `irqReq` is 0.
- R6: A write of control bit 1 = 0 (`regWrEn`=1, `regSel`=0) clears the in-service flag, so a pending request can be raised again (nesting).
- R7: An `irqRet` pulse clears the in-service flag. When it coincides with a control-register write, the return wins over the written bit 1.
- R8: An `irqAck` that coincides with a software clear or with `irqRet` leaves the in-service flag set.
- R9: Control bit 5 is written by software and drives `clkGateDis`. A mask write (`regSel`=1) changes neither control bit 0 nor control bit 5.
- R10: Control bits 7:6 and 4:2, and mask bit 6, always read 0, even after a write of 8'hFF. A control write does not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control register, 1 selects the mask register |
| regWrData | input | 8 | Write data |
| modPend | input | 6 | Pending request, one line per register module |
| sysPend | input | 1 | Combined pending request of the system modules |
| irqAck | input | 1 | Interrupt acknowledge from the core |
| irqRet | input | 1 | Return or pop-interrupt strobe from the core |
| ctrlValue | output | 8 | Control register readback |
| maskValue | output | 8 | Mask register readback |
| irqReq | output | 1 | Qualified interrupt request to the core |
| clkGateDis | output | 1 | Clock-gating disable |

## Verification
On every cycle, the assertions check that no request leaves while the global enable is off or the in-service flag is set. They also check that the reserved bits read zero, that an acknowledge sets the flag, that a return without an acknowledge clears it, and that a plain control write lands as written. Only the bench's scenarios can show the following:
- the exact request value for particular pending and mask combinations;
- the gating of the system line;
- nesting after a software clear;
- the outcome when acknowledge, return and software writes coincide.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int REG_W        = 8;
  localparam int GE_BIT       = 0;
  localparam int INS_BIT      = 1;
  localparam int CGD_BIT      = 5;
  localparam int SYS_MASK_BIT = 7;

  typedef struct packed {
    logic ctrlWr;
    logic maskWr;
    logic ack;
    logic ret;
  } gateStrobes_t;
endpackage

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
(
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         irqAck,
  input  logic         irqRet,
  output gateStrobes_t strobes
);
  always_comb begin
    strobes.ctrlWr = regWrEn && !regSel;
    strobes.maskWr = regWrEn && regSel;
    strobes.ack    = irqAck;
    strobes.ret    = irqRet;
  end
endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int NUM_MODULES = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  gateStrobes_t           strobes,
  input  logic [REG_W-1:0]       wrData,
  input  logic [NUM_MODULES-1:0] modPend,
  input  logic                   sysPend,
  output logic [REG_W-1:0]       ctrlValue,
  output logic [REG_W-1:0]       maskValue,
  output logic                   irqReq,
  output logic                   clkGateDis
);
  localparam int GROUPS = NUM_MODULES + 1;

  logic                   globalEn, inService, gateDis;
  logic [NUM_MODULES-1:0] modMask;
  logic                   sysMask;
  logic [GROUPS-1:0]      groupHit;

  // Control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      gateDis  <= 1'b0;
    end else if (strobes.ctrlWr) begin
      globalEn <= wrData[GE_BIT];
      gateDis  <= wrData[CGD_BIT];
    end
  end

  // In-service flag: acknowledge beats return, return beats software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               inService <= 1'b0;
    else if (strobes.ack)    inService <= 1'b1;
    else if (strobes.ret)    inService <= 1'b0;
    else if (strobes.ctrlWr) inService <= wrData[INS_BIT];
  end

  // Per-module mask flops and request gating
  generate
    for (genvar g = 0; g < NUM_MODULES; g++) begin : g_mod
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               modMask[g] <= 1'b0;
        else if (strobes.maskWr) modMask[g] <= wrData[g];
      end
      assign groupHit[g] = modPend[g] & modMask[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sysMask <= 1'b0;
    else if (strobes.maskWr) sysMask <= wrData[SYS_MASK_BIT];
  end
  assign groupHit[GROUPS-1] = sysPend & sysMask;

  assign irqReq     = globalEn & ~inService & (|groupHit);
  assign clkGateDis = gateDis;

  always_comb begin
    ctrlValue          = '0;
    ctrlValue[GE_BIT]  = globalEn;
    ctrlValue[INS_BIT] = inService;
    ctrlValue[CGD_BIT] = gateDis;
    maskValue          = '0;
    maskValue[NUM_MODULES-1:0] = modMask;
    maskValue[SYS_MASK_BIT]    = sysMask;
  end

  p_ack_sets_ins_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ack |=> ctrlValue[INS_BIT]);
  p_ret_clears_ins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ret && !strobes.ack) |=> !ctrlValue[INS_BIT]);
  p_ctrl_write_lands_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ctrlWr && !strobes.ack && !strobes.ret) |=>
      (ctrlValue[GE_BIT] == $past(wrData[GE_BIT])) &&
      (clkGateDis == $past(wrData[CGD_BIT])) &&
      (ctrlValue[INS_BIT] == $past(wrData[INS_BIT])));
  p_mask_write_keeps_ctrl_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.maskWr && !strobes.ack && !strobes.ret) |=> $stable(ctrlValue));
endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
  import irq_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [7:0] regWrData,
  input  logic [5:0] modPend,
  input  logic       sysPend,
  input  logic       irqAck,
  input  logic       irqRet,
  output logic [7:0] ctrlValue,
  output logic [7:0] maskValue,
  output logic       irqReq,
  output logic       clkGateDis
);
  gateStrobes_t strobes;

  irq_gate_ctrl u_ctrl (
    .regWrEn(regWrEn), .regSel(regSel), .irqAck(irqAck), .irqRet(irqRet),
    .strobes(strobes)
  );

  irq_gate_dp #(.NUM_MODULES(6)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .modPend(modPend), .sysPend(sysPend),
    .ctrlValue(ctrlValue), .maskValue(maskValue),
    .irqReq(irqReq), .clkGateDis(clkGateDis)
  );

  p_no_req_when_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlValue[GE_BIT] |-> !irqReq);
  p_in_service_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlValue[INS_BIT] |-> !irqReq);
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValue[7:6] == 2'b00) && (ctrlValue[4:2] == 3'b000) && !maskValue[6]);
endmodule

// File: tb/sim_irq_gate_unit.sv
module sim_irq_gate_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regSel = 1'b0, sysPend = 1'b0, irqAck = 1'b0, irqRet = 1'b0;
  logic [7:0] regWrData = '0;
  logic [5:0] modPend = '0;
  logic [7:0] ctrlValue, maskValue;
  logic       irqReq, clkGateDis;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_gate_unit u0 (.*);

  // behavioural reference
  bit mGe = 0, mIns = 0, mCgd = 0;
  bit [7:0] mMask = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mGe <= 0; mIns <= 0; mCgd <= 0; mMask <= 0;
    end else begin
      if (irqAck) mIns <= 1;
      else if (irqRet) mIns <= 0;
      else if (regWrEn && !regSel) mIns <= regWrData[1];
      if (regWrEn && !regSel) begin mGe <= regWrData[0]; mCgd <= regWrData[5]; end
      if (regWrEn && regSel) mMask <= regWrData & 8'hBF;
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    bit expReq;
    expReq = mGe && !mIns && ((|(modPend & mMask[5:0])) || (sysPend && mMask[7]));
    cmp(tag, "ctrlValue", ctrlValue, {2'b00, mCgd, 3'b000, mIns, mGe});
    cmp(tag, "maskValue", maskValue, mMask);
    cmp(tag, "irqReq", irqReq, expReq);
    cmp(tag, "clkGateDis", clkGateDis, mCgd);
  endtask

  task automatic step(bit wr, bit sel, logic [7:0] d, logic [5:0] p, bit s,
                      bit ack, bit ret, string tag);
    @(negedge clk);
    regWrEn = wr; regSel = sel; regWrData = d; modPend = p; sysPend = s;
    irqAck = ack; irqRet = ret;
    #5 checkAll(tag);
  endtask

  initial begin
    #5 checkAll("R1");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 8'h00, 6'h3F, 1, 0, 0, "R1");
    step(1, 1, 8'hFF, 6'h3F, 1, 0, 0, "R2");        // mask all, GE still 0
    step(0, 0, 8'h00, 6'h3F, 1, 0, 0, "R10");       // mask bit 6 reads 0
    step(1, 0, 8'hFF, 6'h00, 0, 0, 0, "R9");        // ctrl all ones, INS set by write
    step(0, 0, 8'h00, 6'h01, 0, 0, 0, "R10");       // reserved reads 0, INS blocks
    step(1, 0, 8'h01, 6'h01, 0, 0, 0, "R3");        // GE=1, INS=0, CGD=0
    step(1, 1, 8'h05, 6'h02, 0, 0, 0, "R3");        // mask 0 and 2 only, module1 pend
    step(0, 0, 8'h00, 6'h02, 0, 0, 0, "R3");
    step(0, 0, 8'h00, 6'h04, 0, 0, 0, "R3");
    step(0, 0, 8'h00, 6'h20, 1, 0, 0, "R4");        // sys masked off
    step(1, 1, 8'h80, 6'h00, 1, 0, 0, "R4");
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R4");        // sys enabled
    step(0, 0, 8'h00, 6'h00, 1, 1, 0, "R5");        // acknowledge
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R5");        // blocked
    step(1, 0, 8'h01, 6'h00, 1, 0, 0, "R6");        // software clears INS
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R6");        // nested request visible
    step(0, 0, 8'h00, 6'h00, 1, 1, 0, "R5");
    step(0, 0, 8'h00, 6'h00, 1, 0, 1, "R7");        // return
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R7");
    step(0, 0, 8'h00, 6'h00, 1, 1, 0, "R8");
    step(1, 0, 8'h03, 6'h00, 1, 0, 1, "R7");        // return beats write of INS=1
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R7");
    step(1, 0, 8'h01, 6'h00, 1, 1, 0, "R8");        // ack beats software clear
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R8");
    step(0, 0, 8'h00, 6'h00, 1, 1, 1, "R8");        // ack beats return
    step(0, 0, 8'h00, 6'h00, 1, 0, 0, "R8");
    step(1, 0, 8'h21, 6'h00, 0, 0, 1, "R9");        // CGD on, GE on
    step(0, 0, 8'h00, 6'h00, 0, 0, 0, "R9");
    step(1, 1, 8'h40, 6'h3F, 1, 0, 0, "R10");       // only reserved mask bit
    step(0, 0, 8'h00, 6'h3F, 1, 0, 0, "R10");
    step(1, 0, 8'h00, 6'h3F, 1, 0, 0, "R2");        // GE off, CGD off
    step(1, 1, 8'hBF, 6'h3F, 1, 0, 0, "R2");
    step(0, 0, 8'h00, 6'h3F, 1, 0, 0, "R2");
    step(1, 0, 8'h01, 6'h3F, 1, 0, 0, "R3");
    step(0, 0, 8'h00, 6'h10, 0, 0, 0, "R3");
    step(0, 0, 8'h00, 6'h00, 0, 0, 0, "R3");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule